// File: doc/BRIEF.md
# Radix-4 Add-Compare-Select with Select-Bit Traceback

This block pairs a four-way add-compare-select (ACS) stage with its matching traceback stage, for a trellis decoder whose path metric cache is meant to hold differences instead of full state metrics. The forward half adds a branch metric to each of four incoming state metrics to form candidates A, B, C and D. It runs all six pairwise subtractions side by side and encodes the survivor as a 2-bit index from their signs. It then reports the survivor value, a metric with an optional log-domain correction, the 2-bit index, and the offsets of B, C and D from A.

The traceback half receives a survivor value, the 2-bit index and the three offsets, as a cache would return them. It first rebuilds A by taking the survivor's own offset away from the survivor. It then adds each offset to A to rebuild B, C and D. All arithmetic wraps modulo 2^W, and comparisons use the sign of the wrapped difference. The result stays correct as long as live candidates lie within half the number range of each other.

Both halves have a single register stage at the output, and each half has its own valid strobe.

Top module: `r4_acs_selpair`

## Requirements
- R1: Candidate k equals (state metric k + branch metric k) mod 2^W. fw_max_o is the largest candidate, where x counts as at least y when (x - y) mod 2^W is below 2^(W-1).
- R2: fw_sel_o gives the survivor index: 0 for A, 1 for B, 2 for C, 3 for D. When it is 0, no offset field is positive as a signed value.
- R3: On ties the lower index wins. A nonzero fw_sel_o therefore means the survivor is strictly above A.
- R4: fw_diff_o holds three W-bit fields, each mod 2^W: bits [W-1:0] hold B-A, bits [2W-1:W] hold C-A, and bits [3W-1:2W] hold D-A.
- R5: tb_cand_o holds four W-bit fields, with A in the lowest field. For the index s, A = tb_win_i - (offset field s-1) when s is nonzero. B, C and D are A plus their offset fields.
- R6: When tb_sel_i is 0, the rebuilt A equals tb_win_i unchanged.
- R7: Each half's outputs appear one clock after a cycle with its valid input high, and the matching valid output is then high. When the valid input is low, the data outputs keep their values.
- R8: While rst_n is low, every output is zero.
- R9: With LOGMAP=1, fw_metric_o = fw_max_o + c, where m is the smallest margin between the survivor and the other three candidates. c is 2 when m is at most 1, 1 when m is 2 or 3, and 0 otherwise. With LOGMAP=0, c is always 0.
- R10: Comparison works across the wrap point. For example, 5 beats 1020 when W=10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fw_vld_i | input | 1 | Forward inputs valid |
| fw_sm_i | input | 4*W | State metrics, A in the lowest field |
| fw_bm_i | input | 4*W | Branch metrics, A in the lowest field |
| fw_vld_o | output | 1 | Forward outputs valid |
| fw_max_o | output | W | Survivor candidate value |
| fw_metric_o | output | W | Survivor plus correction term |
| fw_sel_o | output | 2 | Survivor index |
| fw_diff_o | output | 3*W | Offsets of B, C and D from A |
| tb_vld_i | input | 1 | Traceback inputs valid |
| tb_win_i | input | W | Stored survivor value |
| tb_sel_i | input | 2 | Stored survivor index |
| tb_diff_i | input | 3*W | Stored offsets from A |
| tb_vld_o | output | 1 | Traceback outputs valid |
| tb_cand_o | output | 4*W | Rebuilt candidates, A in the lowest field |

## Verification
The assertions check these properties on every cycle:
- The reported index agrees with the signs of the reported offsets, which covers the survivor choice and the tie rule.
- The correction term stays within its bound.
- The valid strobes follow their inputs, and the outputs hold their values when no new input is valid.
- The rebuilt A equals the survivor whenever the index is 0, and the rebuilt B keeps its stored offset from A.

Only the bench scenarios can show the following:
- The survivor is truly the maximum of sums that the assertions never see.
- Traceback returns the exact original four candidates, including across the wrap point.

// File: rtl/r4acs_pkg.sv
package r4acs_pkg;
   localparam int unsigned NUM_CAND = 4;
   localparam int unsigned SEL_W    = 2;
   localparam int unsigned NUM_PAIR = NUM_CAND * (NUM_CAND - 1) / 2;
   localparam int unsigned NUM_OFS  = NUM_CAND - 1;

   typedef logic [SEL_W-1:0] sel_t;

   // lower-indexed member of pair p
   function automatic int unsigned pair_first(int unsigned p);
      if (p < 3)      return 0;
      else if (p < 5) return 1;
      else            return 2;
   endfunction

   // higher-indexed member of pair p
   function automatic int unsigned pair_second(int unsigned p);
      case (p)
         0:       return 1;
         1:       return 2;
         3:       return 2;
         default: return 3;
      endcase
   endfunction
endpackage

// File: rtl/r4_pair_cmp.sv
module r4_pair_cmp
   import r4acs_pkg::*;
#(
   parameter int unsigned W = 10
)(
   input  logic [W-1:0] cand_i  [NUM_CAND],
   output logic [W-1:0] pdiff_o [NUM_PAIR],
   output logic         ge_o    [NUM_PAIR]
);
   // every pair is subtracted in one flat level
   for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
      localparam int unsigned F = pair_first(p);
      localparam int unsigned S = pair_second(p);
      assign pdiff_o[p] = cand_i[F] - cand_i[S];
      assign ge_o[p]    = ~pdiff_o[p][W-1];
   end
endmodule

// File: rtl/r4_sel_enc.sv
module r4_sel_enc
   import r4acs_pkg::*;
(
   input  logic ge_i [NUM_PAIR],
   output sel_t sel_o
);
   // pair order: AB, AC, AD, BC, BD, CD
   logic a_top, b_top, c_top;

   always_comb begin
      a_top = ge_i[0] & ge_i[1] & ge_i[2];
      b_top = ~ge_i[0] & ge_i[3] & ge_i[4];
      c_top = ~ge_i[1] & ~ge_i[3] & ge_i[5];
      if (a_top)      sel_o = 2'd0;
      else if (b_top) sel_o = 2'd1;
      else if (c_top) sel_o = 2'd2;
      else            sel_o = 2'd3;
   end
endmodule

// File: rtl/r4_margin_corr.sv
module r4_margin_corr
   import r4acs_pkg::*;
#(
   parameter int unsigned W      = 10,
   parameter bit          LOGMAP = 1'b1
)(
   input  sel_t         sel_i,
   input  logic [W-1:0] pdiff_i [NUM_PAIR],
   output logic [W-1:0] corr_o
);
   logic [W-1:0] mrg [NUM_OFS];
   logic [W-1:0] m01, mmin;

   always_comb begin
      case (sel_i)
         2'd0: begin mrg[0] = pdiff_i[0];  mrg[1] = pdiff_i[1];  mrg[2] = pdiff_i[2];  end
         2'd1: begin mrg[0] = -pdiff_i[0]; mrg[1] = pdiff_i[3];  mrg[2] = pdiff_i[4];  end
         2'd2: begin mrg[0] = -pdiff_i[1]; mrg[1] = -pdiff_i[3]; mrg[2] = pdiff_i[5];  end
         default: begin mrg[0] = -pdiff_i[2]; mrg[1] = -pdiff_i[4]; mrg[2] = -pdiff_i[5]; end
      endcase
      m01  = (mrg[0] < mrg[1]) ? mrg[0] : mrg[1];
      mmin = (m01 < mrg[2]) ? m01 : mrg[2];
   end

   if (LOGMAP) begin : g_logmap
      always_comb begin
         if (mmin <= W'(1))      corr_o = W'(2);
         else if (mmin <= W'(3)) corr_o = W'(1);
         else                    corr_o = '0;
      end
   end else begin : g_maxlog
      logic [W-1:0] unused_m;
      assign unused_m = mmin;
      assign corr_o   = '0;
   end
endmodule

// File: rtl/r4_acs_fwd.sv
module r4_acs_fwd
   import r4acs_pkg::*;
#(
   parameter int unsigned W      = 10,
   parameter bit          LOGMAP = 1'b1
)(
   input  logic [W-1:0] sm_i   [NUM_CAND],
   input  logic [W-1:0] bm_i   [NUM_CAND],
   output logic [W-1:0] win_o,
   output logic [W-1:0] metric_o,
   output sel_t         sel_o,
   output logic [W-1:0] ofs_o  [NUM_OFS]
);
   logic [W-1:0] cand  [NUM_CAND];
   logic [W-1:0] pdiff [NUM_PAIR];
   logic         ge    [NUM_PAIR];
   logic [W-1:0] corr;

   for (genvar k = 0; k < NUM_CAND; k++) begin : g_add
      assign cand[k] = sm_i[k] + bm_i[k];
   end

   r4_pair_cmp #(.W(W)) i_cmp (
      .cand_i  (cand),
      .pdiff_o (pdiff),
      .ge_o    (ge)
   );

   r4_sel_enc i_enc (
      .ge_i  (ge),
      .sel_o (sel_o)
   );

   r4_margin_corr #(.W(W), .LOGMAP(LOGMAP)) i_corr (
      .sel_i   (sel_o),
      .pdiff_i (pdiff),
      .corr_o  (corr)
   );

   // the first three pairs are A minus B/C/D; offsets are their negation
   for (genvar k = 0; k < NUM_OFS; k++) begin : g_ofs
      assign ofs_o[k] = -pdiff[k];
   end

   assign win_o    = cand[sel_o];
   assign metric_o = win_o + corr;
endmodule

// File: rtl/r4_tbu.sv
module r4_tbu
   import r4acs_pkg::*;
#(
   parameter int unsigned W = 10
)(
   input  logic [W-1:0] win_i,
   input  sel_t         sel_i,
   input  logic [W-1:0] ofs_i  [NUM_OFS],
   output logic [W-1:0] cand_o [NUM_CAND]
);
   logic [W-1:0] base;

   always_comb begin
      case (sel_i)
         2'd0:    base = win_i;
         2'd1:    base = win_i - ofs_i[0];
         2'd2:    base = win_i - ofs_i[1];
         default: base = win_i - ofs_i[2];
      endcase
   end

   assign cand_o[0] = base;
   for (genvar k = 0; k < NUM_OFS; k++) begin : g_rebuild
      assign cand_o[k+1] = base + ofs_i[k];
   end
endmodule

// File: rtl/r4_acs_selpair.sv
module r4_acs_selpair
   import r4acs_pkg::*;
#(
   parameter int unsigned W      = 10,
   parameter bit          LOGMAP = 1'b1
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  fw_vld_i,
   input  logic [NUM_CAND*W-1:0] fw_sm_i,
   input  logic [NUM_CAND*W-1:0] fw_bm_i,
   output logic                  fw_vld_o,
   output logic [W-1:0]          fw_max_o,
   output logic [W-1:0]          fw_metric_o,
   output logic [SEL_W-1:0]      fw_sel_o,
   output logic [NUM_OFS*W-1:0]  fw_diff_o,
   input  logic                  tb_vld_i,
   input  logic [W-1:0]          tb_win_i,
   input  logic [SEL_W-1:0]      tb_sel_i,
   input  logic [NUM_OFS*W-1:0]  tb_diff_i,
   output logic                  tb_vld_o,
   output logic [NUM_CAND*W-1:0] tb_cand_o
);
   if (W < 4 || W > 32) begin : g_bad_width
      $error("r4_acs_selpair: W must lie in 4..32");
   end

   logic [W-1:0] sm      [NUM_CAND];
   logic [W-1:0] bm      [NUM_CAND];
   logic [W-1:0] f_ofs   [NUM_OFS];
   logic [W-1:0] t_ofs   [NUM_OFS];
   logic [W-1:0] t_cand  [NUM_CAND];
   logic [W-1:0] f_win, f_metric;
   sel_t         f_sel;
   logic [NUM_OFS*W-1:0]  f_ofs_flat;
   logic [NUM_CAND*W-1:0] t_cand_flat;

   for (genvar k = 0; k < NUM_CAND; k++) begin : g_unpack_c
      assign sm[k] = fw_sm_i[k*W +: W];
      assign bm[k] = fw_bm_i[k*W +: W];
      assign t_cand_flat[k*W +: W] = t_cand[k];
   end
   for (genvar k = 0; k < NUM_OFS; k++) begin : g_unpack_o
      assign t_ofs[k] = tb_diff_i[k*W +: W];
      assign f_ofs_flat[k*W +: W] = f_ofs[k];
   end

   r4_acs_fwd #(.W(W), .LOGMAP(LOGMAP)) i_fwd (
      .sm_i     (sm),
      .bm_i     (bm),
      .win_o    (f_win),
      .metric_o (f_metric),
      .sel_o    (f_sel),
      .ofs_o    (f_ofs)
   );

   r4_tbu #(.W(W)) i_tbu (
      .win_i  (tb_win_i),
      .sel_i  (tb_sel_i),
      .ofs_i  (t_ofs),
      .cand_o (t_cand)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fw_vld_o    <= 1'b0;
         fw_max_o    <= '0;
         fw_metric_o <= '0;
         fw_sel_o    <= '0;
         fw_diff_o   <= '0;
      end else begin
         fw_vld_o <= fw_vld_i;
         if (fw_vld_i) begin
            fw_max_o    <= f_win;
            fw_metric_o <= f_metric;
            fw_sel_o    <= f_sel;
            fw_diff_o   <= f_ofs_flat;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tb_vld_o  <= 1'b0;
         tb_cand_o <= '0;
      end else begin
         tb_vld_o <= tb_vld_i;
         if (tb_vld_i) tb_cand_o <= t_cand_flat;
      end
   end
endmodule

// File: rtl/r4_acs_selpair_chk.sv
module r4_acs_selpair_chk #(
   parameter int unsigned W      = 10,
   parameter bit          LOGMAP = 1'b1
)(
   input logic           clk,
   input logic           rst_n,
   input logic           fw_vld_i,
   input logic           fw_vld_o,
   input logic [W-1:0]   fw_max_o,
   input logic [W-1:0]   fw_metric_o,
   input logic [1:0]     fw_sel_o,
   input logic [3*W-1:0] fw_diff_o,
   input logic           tb_vld_i,
   input logic [W-1:0]   tb_win_i,
   input logic [1:0]     tb_sel_i,
   input logic [3*W-1:0] tb_diff_i,
   input logic           tb_vld_o,
   input logic [4*W-1:0] tb_cand_o
);
   logic [W-1:0] sel_ofs, corr_seen, b_minus_a;

   always_comb begin
      case (fw_sel_o)
         2'd1:    sel_ofs = fw_diff_o[W-1:0];
         2'd2:    sel_ofs = fw_diff_o[2*W-1:W];
         default: sel_ofs = fw_diff_o[3*W-1:2*W];
      endcase
   end
   assign corr_seen = fw_metric_o - fw_max_o;
   assign b_minus_a = tb_cand_o[2*W-1:W] - tb_cand_o[W-1:0];

   // R8: outputs cleared while reset is held
   a_r8_reset_clear: assert property (@(posedge clk)
      !rst_n |=> (!fw_vld_o && !tb_vld_o && tb_cand_o == '0 && fw_max_o == '0));

   // R7: valid strobes track their inputs by one cycle
   a_r7_fw_valid: assert property (@(posedge clk) disable iff (!rst_n)
      fw_vld_i |=> fw_vld_o);
   a_r7_tb_valid: assert property (@(posedge clk) disable iff (!rst_n)
      tb_vld_i |=> tb_vld_o);

   // R7: outputs hold without a new valid input
   a_r7_fw_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !fw_vld_i |=> ($stable(fw_max_o) && $stable(fw_sel_o) && $stable(fw_diff_o)));
   a_r7_tb_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !tb_vld_i |=> $stable(tb_cand_o));

   // R2: survivor A means no offset is positive
   a_r2_a_on_top: assert property (@(posedge clk) disable iff (!rst_n)
      (fw_vld_o && fw_sel_o == 2'd0) |->
         ($signed(fw_diff_o[W-1:0]) <= 0 && $signed(fw_diff_o[2*W-1:W]) <= 0
          && $signed(fw_diff_o[3*W-1:2*W]) <= 0));

   // R3: a nonzero index needs a strictly larger survivor than A
   a_r3_strict_over_a: assert property (@(posedge clk) disable iff (!rst_n)
      (fw_vld_o && fw_sel_o != 2'd0) |-> ($signed(sel_ofs) > 0));

   // R9: correction bounded, absent in max-log mode
   a_r9_corr_bound: assert property (@(posedge clk) disable iff (!rst_n)
      fw_vld_o |-> (LOGMAP ? (corr_seen <= W'(2)) : (corr_seen == '0)));

   // R6: index 0 keeps the survivor as A
   a_r6_base_direct: assert property (@(posedge clk) disable iff (!rst_n)
      (tb_vld_i && tb_sel_i == 2'd0) |=> (tb_cand_o[W-1:0] == $past(tb_win_i)));

   // R5: rebuilt B keeps its stored offset from A
   a_r5_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
      tb_vld_i |=> (b_minus_a == $past(tb_diff_i[W-1:0])));
endmodule

bind r4_acs_selpair r4_acs_selpair_chk #(.W(W), .LOGMAP(LOGMAP)) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .fw_vld_i    (fw_vld_i),
   .fw_vld_o    (fw_vld_o),
   .fw_max_o    (fw_max_o),
   .fw_metric_o (fw_metric_o),
   .fw_sel_o    (fw_sel_o),
   .fw_diff_o   (fw_diff_o),
   .tb_vld_i    (tb_vld_i),
   .tb_win_i    (tb_win_i),
   .tb_sel_i    (tb_sel_i),
   .tb_diff_i   (tb_diff_i),
   .tb_vld_o    (tb_vld_o),
   .tb_cand_o   (tb_cand_o)
);

// File: tb/test_r4_acs_selpair.sv
`timescale 1ns/1ps
module test_r4_acs_selpair;
   localparam int W    = 10;
   localparam int MOD  = 1 << W;
   localparam int HALF = 1 << (W-1);
   localparam int NV   = 12;

   // state metrics and branch metrics per vector, index 0 = A
   localparam int VSM [NV][4] = '{
      '{100, 200, 50, 30}, '{300, 10, 20, 30}, '{10, 20, 400, 399}, '{1, 2, 3, 4},
      '{50, 50, 10, 10},   '{1, 2, 70, 60},    '{1020, 5, 1000, 1010}, '{1000, 1000, 1000, 1000},
      '{7, 7, 7, 7},       '{0, 3, 1, 2},      '{600, 598, 597, 590},  '{0, 0, 0, 1023}};
   localparam int VBM [NV][4] = '{
      '{0, 0, 0, 0},  '{5, 5, 5, 5}, '{0, 0, 0, 0}, '{0, 0, 0, 10},
      '{0, 0, 0, 0},  '{0, 0, 0, 10}, '{0, 0, 0, 0}, '{30, 10, 20, 0},
      '{0, 0, 0, 0},  '{0, 0, 0, 0}, '{0, 0, 0, 0}, '{0, 0, 0, 0}};

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           fw_vld_i = 1'b0;
   logic [4*W-1:0] fw_sm_i = '0, fw_bm_i = '0;
   logic           fw_vld_o;
   logic [W-1:0]   fw_max_o, fw_metric_o;
   logic [1:0]     fw_sel_o;
   logic [3*W-1:0] fw_diff_o;
   logic           tb_vld_i = 1'b0;
   logic [W-1:0]   tb_win_i = '0;
   logic [1:0]     tb_sel_i = '0;
   logic [3*W-1:0] tb_diff_i = '0;
   logic           tb_vld_o;
   logic [4*W-1:0] tb_cand_o;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   r4_acs_selpair #(.W(W), .LOGMAP(1'b1)) i_r4_acs_selpair (
      .clk(clk), .rst_n(rst_n),
      .fw_vld_i(fw_vld_i), .fw_sm_i(fw_sm_i), .fw_bm_i(fw_bm_i),
      .fw_vld_o(fw_vld_o), .fw_max_o(fw_max_o), .fw_metric_o(fw_metric_o),
      .fw_sel_o(fw_sel_o), .fw_diff_o(fw_diff_o),
      .tb_vld_i(tb_vld_i), .tb_win_i(tb_win_i), .tb_sel_i(tb_sel_i),
      .tb_diff_i(tb_diff_i), .tb_vld_o(tb_vld_o), .tb_cand_o(tb_cand_o));

   task automatic chk(input string req, input longint act, input longint exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int wrapd(int x, int y);
      return ((x - y) % MOD + MOD) % MOD;
   endfunction

   task automatic run_vec(input int v);
      int c[4];
      int best, m, corr;
      logic [4*W-1:0] cpack;
      logic [3*W-1:0] opack;
      for (int k = 0; k < 4; k++) begin
         c[k] = (VSM[v][k] + VBM[v][k]) % MOD;
         cpack[k*W +: W] = W'(c[k]);
      end
      best = 0;
      for (int k = 1; k < 4; k++) begin
         int d = wrapd(c[k], c[best]);
         if (d != 0 && d < HALF) best = k;
      end
      m = MOD;
      for (int k = 0; k < 4; k++)
         if (k != best && wrapd(c[best], c[k]) < m) m = wrapd(c[best], c[k]);
      corr = (m <= 1) ? 2 : (m <= 3) ? 1 : 0;
      for (int k = 0; k < 3; k++) opack[k*W +: W] = W'(wrapd(c[k+1], c[0]));

      @(negedge clk);
      for (int k = 0; k < 4; k++) begin
         fw_sm_i[k*W +: W] = W'(VSM[v][k]);
         fw_bm_i[k*W +: W] = W'(VBM[v][k]);
      end
      fw_vld_i = 1'b1;
      @(negedge clk);
      fw_vld_i = 1'b0;
      chk("R1 survivor/R10 wrap", fw_max_o, c[best]);
      chk("R2 index/R3 tie", fw_sel_o, best);
      chk("R4 offsets", fw_diff_o, opack);
      chk("R9 metric", fw_metric_o, (c[best] + corr) % MOD);
      chk("R7 fw valid", fw_vld_o, 1);
      tb_win_i = fw_max_o; tb_sel_i = fw_sel_o; tb_diff_i = fw_diff_o; tb_vld_i = 1'b1;
      @(negedge clk);
      tb_vld_i = 1'b0;
      chk("R5 roundtrip", tb_cand_o, cpack);
      chk("R7 tb valid", tb_vld_o, 1);
   endtask

   initial begin
      #2000000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (2) @(negedge clk);
      chk("R8 reset fw_vld", fw_vld_o, 0);
      chk("R8 reset cand", tb_cand_o, 0);
      chk("R8 reset max", fw_max_o, 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int v = 0; v < NV; v++) run_vec(v);

      // R7: inputs change with valid low; outputs must hold (last vector: A survives at 0)
      fw_sm_i = {10'd1, 10'd900, 10'd2, 10'd3};
      tb_win_i = 10'd77; tb_sel_i = 2'd2;
      @(negedge clk);
      chk("R7 hold max", fw_max_o, 0);
      chk("R7 hold sel", fw_sel_o, 0);
      chk("R7 hold cand", tb_cand_o, {10'd1023, 10'd0, 10'd0, 10'd0});
      chk("R7 fw valid drop", fw_vld_o, 0);

      // R6: index 0 rebuilds A as the survivor itself
      tb_win_i = 10'd500; tb_sel_i = 2'd0;
      tb_diff_i = {10'd1000, 10'd20, 10'd1}; tb_vld_i = 1'b1;
      @(negedge clk);
      tb_vld_i = 1'b0;
      chk("R6 direct A", tb_cand_o, {10'd476, 10'd520, 10'd501, 10'd500});

      // R5: index 3 subtracts the D offset
      tb_win_i = 10'd10; tb_sel_i = 2'd3;
      tb_diff_i = {10'd20, 10'd5, 10'd1020}; tb_vld_i = 1'b1;
      @(negedge clk);
      tb_vld_i = 1'b0;
      chk("R5 index3", tb_cand_o, {10'd10, 10'd1019, 10'd1010, 10'd1014});

      // R8: reset mid-run clears outputs
      rst_n = 1'b0;
      @(negedge clk);
      chk("R8 mid reset cand", tb_cand_o, 0);
      chk("R8 mid reset metric", fw_metric_o, 0);
      rst_n = 1'b1;

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule